// File: doc/BRIEF.md
# Journaled Flash Sector Update Sequencer

This controller changes one byte of a NOR-style flash sector so that a power loss at any moment leaves the sector holding either its complete old image or its complete new image. Erasing is only possible for a whole sector, and an erased byte reads 0xFF. Three sectors are kept apart as a journal. The address sector records which sector is being changed. The data sector holds a staged copy of that sector with the new byte already merged in. The flag sector holds a commit byte. The destination is only erased once the staged copy is complete and the commit byte has been programmed.

A client hands over one update at a time on a valid/ready request port. Each request carries the sector index, the byte offset and the new byte value. The client holds `req_valid` and the fields steady until `req_ready` is seen high on a rising edge, and that edge is the handshake. `req_ready` is high only when the controller has nothing to do, so back-pressure lasts for the whole update. It also lasts for the whole recovery pass that runs after every reset. The controller drives an abstract flash command port: one command at a time, issued only while the flash is not busy, and complete when the flash returns a done pulse. When the flag byte reads as anything other than 0xFF after a reset, the controller finishes the interrupted commit. It takes the destination from the address sector and restarts at the destination erase.

Top module: `sector_journal_seq`

## Requirements
- R1: The command port uses the op codes 1 for erase sector, 2 for program byte and 3 for read byte. `fl_cmd_valid` is high for exactly one cycle per command and only while `fl_busy` is low. A new command is issued only after `fl_done` has answered the previous one.
- R2: While reset is held, `req_ready`, `upd_done` and `fl_cmd_valid` are low. After reset is released, the first command reads byte 0 of the flag sector, and `req_ready` stays low until the recovery pass has finished.
- R3: If that flag byte reads 0xFF, no further command is issued and the controller becomes ready.
- R4: If the flag byte reads anything else, the controller reads byte 0 of the address sector and takes that byte as the destination index. It then erases that sector, copies the data sector into it, erases the flag sector and pulses `upd_done`.
- R5: A request is taken on a cycle with `req_valid` and `req_ready` both high. `req_ready` then stays low until the update has ended. A request offered while `req_ready` is low is not lost: it is taken once `req_ready` rises.
- R6: An update starts by erasing the address sector. It then programs the destination index, zero-extended to 8 bits, into byte 0 of that sector, and then erases the data sector.
- R7: The update then copies every byte of the destination into the data sector, with the new byte at the requested offset. Only after the last staging write does it program 0x00 into byte 0 of the flag sector. The data sector is never erased or programmed while the commit byte is set.
- R8: After the commit, the controller erases the destination and copies the data sector back into it. It then erases the flag sector. `upd_done` is high for one cycle once that erase completes, in the cycle where `req_ready` returns high.
- R9: During both copies, a byte whose value is 0xFF is not programmed, because the erased target already holds it.
- R10: If power is lost at any point of an update and the controller is then reset, the destination ends up holding the full old image or the full new image. It always holds the new image when the commit byte was completely programmed before the loss. The flag byte reads 0xFF once the controller is ready again.
- R11: A sector outside the journal is erased only while a commit is pending, that is, after the flag byte has been programmed or read back as non-0xFF, and before the flag sector is erased.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low; starts the recovery pass |
| req_valid | input | 1 | Update request offered |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_sector | input | SECT_W | Destination sector index |
| req_offset | input | OFF_W | Byte offset inside the destination sector |
| req_data | input | 8 | New byte value |
| upd_done | output | 1 | One-cycle pulse when an update or a recovered commit has finished |
| fl_cmd_valid | output | 1 | Flash command issued this cycle |
| fl_cmd_op | output | 2 | 1 erase sector, 2 program byte, 3 read byte |
| fl_cmd_sector | output | SECT_W | Sector index of the command |
| fl_cmd_offset | output | OFF_W | Byte offset of a program or read |
| fl_cmd_wdata | output | 8 | Byte to program |
| fl_busy | input | 1 | Flash is working on a command or is otherwise occupied |
| fl_done | input | 1 | One-cycle pulse when the current command has completed |
| fl_rdata | input | 8 | Read result, valid with `fl_done` |

## Verification
The assertions check on every cycle the rules that hold at the command port and at the handshake. They check that commands are gated by busy and never overlap. They check that a foreign sector is erased only while a commit is pending, and that the data sector stays untouched during that window. They also check that the commit byte is always 0x00, that `req_ready` drops after a request is taken, and that the done pulse lasts one cycle and coincides with the return to idle. Other properties can only be shown by the bench's scenarios, because each one depends on flash contents over a whole update. These are the exact command order, the skipping of 0xFF bytes, recovery from a preloaded commit, and the result after a power cut at dozens of points across an update with partial erase and partial program corruption.

// File: rtl/sjs_pkg.sv
package sjs_pkg;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_ERASE = 2'd1,
    OP_PROG  = 2'd2,
    OP_READ  = 2'd3
  } fl_op_e;

  typedef enum logic [3:0] {
    S_REC_FLAG,
    S_REC_ADDR,
    S_IDLE,
    S_ER_ADDR,
    S_PG_ADDR,
    S_ER_DATA,
    S_STG_RD,
    S_STG_PG,
    S_PG_FLAG,
    S_ER_DEST,
    S_BCK_RD,
    S_BCK_PG,
    S_ER_FLAG
  } seq_state_e;

  localparam logic [7:0] BYTE_ERASED = 8'hFF;
  localparam logic [7:0] BYTE_COMMIT = 8'h00;

endpackage

// File: rtl/sjs_cmd_port.sv
// Holds one flash command until the device is free, then waits for its completion.
module sjs_cmd_port import sjs_pkg::*; #(
  parameter int SECT_W = 8,
  parameter int OFF_W  = 12
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  fl_op_e            op,
  input  logic [SECT_W-1:0] sect,
  input  logic [OFF_W-1:0]  off,
  input  logic [7:0]        wdata,
  input  logic              fl_busy,
  input  logic              fl_done,
  input  logic [7:0]        fl_rdata,
  output logic              fl_cmd_valid,
  output logic [1:0]        fl_cmd_op,
  output logic [SECT_W-1:0] fl_cmd_sector,
  output logic [OFF_W-1:0]  fl_cmd_offset,
  output logic [7:0]        fl_cmd_wdata,
  output logic              rsp_done,
  output logic [7:0]        rsp_data
);
  logic              pend_q;
  logic              wait_q;
  fl_op_e            op_q;
  logic [SECT_W-1:0] sect_q;
  logic [OFF_W-1:0]  off_q;
  logic [7:0]        wd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      wait_q <= 1'b0;
      op_q   <= OP_NONE;
      sect_q <= '0;
      off_q  <= '0;
      wd_q   <= BYTE_ERASED;
    end else begin
      if (start) begin
        pend_q <= 1'b1;
        op_q   <= op;
        sect_q <= sect;
        off_q  <= off;
        wd_q   <= wdata;
      end else if (pend_q && !fl_busy) begin
        pend_q <= 1'b0;
        wait_q <= 1'b1;
      end else if (wait_q && fl_done) begin
        wait_q <= 1'b0;
      end
    end
  end

  assign fl_cmd_valid  = pend_q && !fl_busy;
  assign fl_cmd_op     = op_q;
  assign fl_cmd_sector = sect_q;
  assign fl_cmd_offset = off_q;
  assign fl_cmd_wdata  = wd_q;
  assign rsp_done      = wait_q && fl_done;
  assign rsp_data      = fl_rdata;
endmodule

// File: rtl/sjs_idx_ctr.sv
// Byte index walked by both sector copies.
module sjs_idx_ctr #(
  parameter int OFF_W = 12
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [OFF_W-1:0] idx,
  output logic             last
);
  logic [OFF_W-1:0] idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   idx_q <= '0;
    else if (clr) idx_q <= '0;
    else if (inc) idx_q <= idx_q + 1'b1;
  end

  assign idx  = idx_q;
  assign last = (idx_q == {OFF_W{1'b1}});
endmodule

// File: rtl/sjs_stage_sel.sv
// Chooses the byte to write during a copy and flags bytes that need no programming.
module sjs_stage_sel import sjs_pkg::*; #(
  parameter int OFF_W = 12
)(
  input  logic             subst_en,
  input  logic [OFF_W-1:0] idx,
  input  logic [OFF_W-1:0] tgt_off,
  input  logic [7:0]       new_byte,
  input  logic [7:0]       rd_byte,
  output logic [7:0]       out_byte,
  output logic             skip
);
  always_comb begin
    out_byte = (subst_en && (idx == tgt_off)) ? new_byte : rd_byte;
    skip     = (out_byte == BYTE_ERASED);
  end
endmodule

// File: rtl/sector_journal_seq.sv
module sector_journal_seq import sjs_pkg::*; #(
  parameter int SECTOR_BYTES = 4096,
  parameter int SECT_W       = 8,
  parameter int FLAG_SECT    = 253,
  parameter int ADDR_SECT    = 254,
  parameter int DATA_SECT    = 255,
  localparam int OFF_W       = $clog2(SECTOR_BYTES)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [SECT_W-1:0] req_sector,
  input  logic [OFF_W-1:0]  req_offset,
  input  logic [7:0]        req_data,
  output logic              upd_done,
  output logic              fl_cmd_valid,
  output logic [1:0]        fl_cmd_op,
  output logic [SECT_W-1:0] fl_cmd_sector,
  output logic [OFF_W-1:0]  fl_cmd_offset,
  output logic [7:0]        fl_cmd_wdata,
  input  logic              fl_busy,
  input  logic              fl_done,
  input  logic [7:0]        fl_rdata
);
  localparam logic [SECT_W-1:0] FLAG_S = SECT_W'(FLAG_SECT);
  localparam logic [SECT_W-1:0] ADDR_S = SECT_W'(ADDR_SECT);
  localparam logic [SECT_W-1:0] DATA_S = SECT_W'(DATA_SECT);

  seq_state_e        state_q;
  logic              issued_q;
  logic [SECT_W-1:0] dest_q;
  logic [OFF_W-1:0]  off_q;
  logic [7:0]        byte_q;
  logic [7:0]        cur_q;
  logic              done_q;

  fl_op_e            c_op;
  logic [SECT_W-1:0] c_sect;
  logic [OFF_W-1:0]  c_off;
  logic [7:0]        c_wd;
  logic              start;
  logic              rsp_done;
  logic [7:0]        rsp_data;
  logic [OFF_W-1:0]  idx;
  logic              idx_last;
  logic              idx_clr;
  logic              idx_inc;
  logic [7:0]        sel_byte;
  logic              sel_skip;
  logic              in_rd;
  logic              in_pg;

  // Command selected by the current step
  always_comb begin
    c_op   = OP_NONE;
    c_sect = '0;
    c_off  = '0;
    c_wd   = BYTE_ERASED;
    case (state_q)
      S_REC_FLAG: begin c_op = OP_READ;  c_sect = FLAG_S; end
      S_REC_ADDR: begin c_op = OP_READ;  c_sect = ADDR_S; end
      S_ER_ADDR:  begin c_op = OP_ERASE; c_sect = ADDR_S; end
      S_PG_ADDR:  begin c_op = OP_PROG;  c_sect = ADDR_S; c_wd = 8'(dest_q); end
      S_ER_DATA:  begin c_op = OP_ERASE; c_sect = DATA_S; end
      S_STG_RD:   begin c_op = OP_READ;  c_sect = dest_q; c_off = idx; end
      S_STG_PG:   begin c_op = OP_PROG;  c_sect = DATA_S; c_off = idx; c_wd = cur_q; end
      S_PG_FLAG:  begin c_op = OP_PROG;  c_sect = FLAG_S; c_wd = BYTE_COMMIT; end
      S_ER_DEST:  begin c_op = OP_ERASE; c_sect = dest_q; end
      S_BCK_RD:   begin c_op = OP_READ;  c_sect = DATA_S; c_off = idx; end
      S_BCK_PG:   begin c_op = OP_PROG;  c_sect = dest_q; c_off = idx; c_wd = cur_q; end
      S_ER_FLAG:  begin c_op = OP_ERASE; c_sect = FLAG_S; end
      default:    c_op = OP_NONE;
    endcase
  end

  assign start = (c_op != OP_NONE) && !issued_q;
  assign in_rd = (state_q == S_STG_RD) || (state_q == S_BCK_RD);
  assign in_pg = (state_q == S_STG_PG) || (state_q == S_BCK_PG);

  assign idx_clr = rsp_done && ((state_q == S_ER_DATA) || (state_q == S_ER_DEST));
  assign idx_inc = rsp_done && !idx_last && ((in_rd && sel_skip) || in_pg);

  sjs_cmd_port #(.SECT_W(SECT_W), .OFF_W(OFF_W)) u_port (
    .clk(clk), .rst_n(rst_n), .start(start), .op(c_op), .sect(c_sect),
    .off(c_off), .wdata(c_wd), .fl_busy(fl_busy), .fl_done(fl_done),
    .fl_rdata(fl_rdata), .fl_cmd_valid(fl_cmd_valid), .fl_cmd_op(fl_cmd_op),
    .fl_cmd_sector(fl_cmd_sector), .fl_cmd_offset(fl_cmd_offset),
    .fl_cmd_wdata(fl_cmd_wdata), .rsp_done(rsp_done), .rsp_data(rsp_data)
  );

  sjs_idx_ctr #(.OFF_W(OFF_W)) u_idx (
    .clk(clk), .rst_n(rst_n), .clr(idx_clr), .inc(idx_inc),
    .idx(idx), .last(idx_last)
  );

  sjs_stage_sel #(.OFF_W(OFF_W)) u_sel (
    .subst_en(state_q == S_STG_RD), .idx(idx), .tgt_off(off_q),
    .new_byte(byte_q), .rd_byte(rsp_data), .out_byte(sel_byte), .skip(sel_skip)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_REC_FLAG;
      issued_q <= 1'b0;
      dest_q   <= '0;
      off_q    <= '0;
      byte_q   <= BYTE_ERASED;
      cur_q    <= BYTE_ERASED;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start) issued_q <= 1'b1;
      if (state_q == S_IDLE) begin
        if (req_valid) begin
          dest_q  <= req_sector;
          off_q   <= req_offset;
          byte_q  <= req_data;
          state_q <= S_ER_ADDR;
        end
      end else if (rsp_done) begin
        issued_q <= 1'b0;
        case (state_q)
          S_REC_FLAG: state_q <= (rsp_data != BYTE_ERASED) ? S_REC_ADDR : S_IDLE;
          S_REC_ADDR: begin
            dest_q  <= rsp_data[SECT_W-1:0];
            state_q <= S_ER_DEST;
          end
          S_ER_ADDR:  state_q <= S_PG_ADDR;
          S_PG_ADDR:  state_q <= S_ER_DATA;
          S_ER_DATA:  state_q <= S_STG_RD;
          S_STG_RD: begin
            cur_q <= sel_byte;
            if (!sel_skip)     state_q <= S_STG_PG;
            else if (idx_last) state_q <= S_PG_FLAG;
          end
          S_STG_PG:   state_q <= idx_last ? S_PG_FLAG : S_STG_RD;
          S_PG_FLAG:  state_q <= S_ER_DEST;
          S_ER_DEST:  state_q <= S_BCK_RD;
          S_BCK_RD: begin
            cur_q <= sel_byte;
            if (!sel_skip)     state_q <= S_BCK_PG;
            else if (idx_last) state_q <= S_ER_FLAG;
          end
          S_BCK_PG:   state_q <= idx_last ? S_ER_FLAG : S_BCK_RD;
          S_ER_FLAG: begin
            done_q  <= 1'b1;
            state_q <= S_IDLE;
          end
          default:    state_q <= S_IDLE;
        endcase
      end
    end
  end

  assign req_ready = (state_q == S_IDLE);
  assign upd_done  = done_q;
endmodule

// File: rtl/sjs_checker.sv
module sjs_checker #(
  parameter int SECT_W    = 8,
  parameter int FLAG_SECT = 253,
  parameter int ADDR_SECT = 254,
  parameter int DATA_SECT = 255
)(
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              upd_done,
  input logic              fl_cmd_valid,
  input logic [1:0]        fl_cmd_op,
  input logic [SECT_W-1:0] fl_cmd_sector,
  input logic [7:0]        fl_cmd_wdata,
  input logic              fl_busy,
  input logic              fl_done,
  input logic [7:0]        fl_rdata
);
  localparam logic [SECT_W-1:0] FS = SECT_W'(FLAG_SECT);
  localparam logic [SECT_W-1:0] AS = SECT_W'(ADDR_SECT);
  localparam logic [SECT_W-1:0] DS = SECT_W'(DATA_SECT);

  logic              armed_q;
  logic [1:0]        last_op_q;
  logic [SECT_W-1:0] last_sect_q;
  logic              foreign;

  assign foreign = (fl_cmd_sector != FS) && (fl_cmd_sector != AS) && (fl_cmd_sector != DS);

  // Commit window tracked from port traffic only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q     <= 1'b0;
      last_op_q   <= 2'd0;
      last_sect_q <= '0;
    end else begin
      if (fl_cmd_valid) begin
        last_op_q   <= fl_cmd_op;
        last_sect_q <= fl_cmd_sector;
        if (fl_cmd_sector == FS && fl_cmd_op == 2'd2) armed_q <= 1'b1;
        if (fl_cmd_sector == FS && fl_cmd_op == 2'd1) armed_q <= 1'b0;
      end else if (fl_done && last_op_q == 2'd3 && last_sect_q == FS && fl_rdata != 8'hFF) begin
        armed_q <= 1'b1;
      end
    end
  end

  p_cmd_not_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    fl_cmd_valid |-> !fl_busy);
  p_cmd_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    fl_cmd_valid |=> !fl_cmd_valid);
  p_accept_drops_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  p_commit_value_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_cmd_valid && fl_cmd_op == 2'd2 && fl_cmd_sector == FS) |-> (fl_cmd_wdata == 8'h00));
  p_stage_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_cmd_valid && fl_cmd_sector == DS && fl_cmd_op != 2'd3) |-> !armed_q);
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    upd_done |=> !upd_done);
  p_done_at_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    upd_done |-> req_ready);
  p_dest_erase_armed_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_cmd_valid && fl_cmd_op == 2'd1 && foreign) |-> armed_q);
endmodule

bind sector_journal_seq sjs_checker #(
  .SECT_W(SECT_W), .FLAG_SECT(FLAG_SECT), .ADDR_SECT(ADDR_SECT), .DATA_SECT(DATA_SECT)
) u_sjs_checker (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .upd_done(upd_done), .fl_cmd_valid(fl_cmd_valid), .fl_cmd_op(fl_cmd_op),
  .fl_cmd_sector(fl_cmd_sector), .fl_cmd_wdata(fl_cmd_wdata), .fl_busy(fl_busy),
  .fl_done(fl_done), .fl_rdata(fl_rdata)
);

// File: tb/test_sector_journal_seq.sv
`timescale 1ns/1ps
module test_sector_journal_seq;
  localparam int SB  = 128;
  localparam int SW  = 3;
  localparam int NS  = 8;
  localparam int FLG = 5;
  localparam int ADR = 6;
  localparam int DAT = 7;
  localparam int OW  = $clog2(SB);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [SW-1:0] req_sector = '0;
  logic [OW-1:0] req_offset = '0;
  logic [7:0] req_data = 8'h00;
  logic upd_done;
  logic fl_cmd_valid;
  logic [1:0] fl_cmd_op;
  logic [SW-1:0] fl_cmd_sector;
  logic [OW-1:0] fl_cmd_offset;
  logic [7:0] fl_cmd_wdata;
  logic m_busy = 1'b0;
  logic m_done = 1'b0;
  logic [7:0] m_rdata = 8'h00;

  always #10 clk = ~clk;

  sector_journal_seq #(.SECTOR_BYTES(SB), .SECT_W(SW), .FLAG_SECT(FLG),
                       .ADDR_SECT(ADR), .DATA_SECT(DAT)) i_sector_journal_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_sector(req_sector), .req_offset(req_offset), .req_data(req_data),
    .upd_done(upd_done), .fl_cmd_valid(fl_cmd_valid), .fl_cmd_op(fl_cmd_op),
    .fl_cmd_sector(fl_cmd_sector), .fl_cmd_offset(fl_cmd_offset),
    .fl_cmd_wdata(fl_cmd_wdata), .fl_busy(m_busy), .fl_done(m_done), .fl_rdata(m_rdata)
  );

  // Behavioural flash: NOR program (AND), erase to 0xFF, corruption on a cut
  logic [7:0] mem [NS*SB];
  logic cut = 1'b0;
  int cnt = 0, hold = 0, viol = 0;
  int a_op = 0, a_sect = 0, a_off = 0;
  logic [7:0] a_wd = 8'h00;
  int cmd_cnt = 0, prog_cnt = 0;
  int lg_op [16], lg_sect [16], lg_wd [16];
  int t_fp = -1, t_ld = -1, t_de = -1, fp_wd = -1;
  bit commit_done = 1'b0;

  always @(posedge clk) begin
    m_done <= 1'b0;
    if (cut) begin
      if (m_busy && cnt > 0) begin
        if (a_op == 1) for (int i = 0; i < SB; i++) mem[a_sect*SB+i] = 8'($urandom);
        if (a_op == 2) mem[a_sect*SB+a_off] = mem[a_sect*SB+a_off] & (a_wd | 8'($urandom));
      end
      m_busy <= 1'b0;
      cnt = 0;
      hold = 0;
    end else if (m_busy) begin
      if (fl_cmd_valid) viol++;
      if (cnt > 0) begin
        cnt--;
        if (cnt == 0) begin
          if (a_op == 1) begin
            for (int i = 0; i < SB; i++) mem[a_sect*SB+i] = 8'hFF;
            if (a_sect == FLG) commit_done = 1'b0;
          end else if (a_op == 2) begin
            mem[a_sect*SB+a_off] = mem[a_sect*SB+a_off] & a_wd;
            if (a_sect == FLG) commit_done = 1'b1;
          end else begin
            m_rdata <= mem[a_sect*SB+a_off];
          end
          m_done <= 1'b1;
          if (hold == 0) m_busy <= 1'b0;
        end
      end else begin
        hold--;
        if (hold <= 0) m_busy <= 1'b0;
      end
    end else if (fl_cmd_valid) begin
      a_op = int'(fl_cmd_op);
      a_sect = int'(fl_cmd_sector);
      a_off = int'(fl_cmd_offset);
      a_wd = fl_cmd_wdata;
      cnt = (a_op == 1) ? 4 : 1;
      hold = int'($urandom % 3);
      m_busy <= 1'b1;
      if (cmd_cnt < 16) begin
        lg_op[cmd_cnt] = a_op; lg_sect[cmd_cnt] = a_sect; lg_wd[cmd_cnt] = int'(a_wd);
      end
      if (a_op == 2) prog_cnt++;
      if (a_op == 2 && a_sect == FLG) begin t_fp = cmd_cnt; fp_wd = int'(a_wd); end
      if (a_op != 3 && a_sect == DAT) t_ld = cmd_cnt;
      if (a_op == 1 && a_sect < FLG) t_de = cmd_cnt;
      cmd_cnt++;
    end
  end

  int checks = 0, fails = 0;
  logic [7:0] old_img [SB];
  logic [7:0] new_img [SB];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] merged(input logic [7:0] ob, input int o, input int off,
                                        input logic [7:0] d);
    return (o == off) ? d : ob;
  endfunction

  function automatic int diff_old(input int s);
    int n = 0;
    for (int o = 0; o < SB; o++) if (mem[s*SB+o] != old_img[o]) n++;
    return n;
  endfunction

  function automatic int diff_new(input int s);
    int n = 0;
    for (int o = 0; o < SB; o++) if (mem[s*SB+o] != new_img[o]) n++;
    return n;
  endfunction

  task automatic fill_old(input int s);
    for (int o = 0; o < SB; o++) begin
      old_img[o] = ($urandom % 3 == 0) ? 8'hFF : 8'($urandom);
      mem[s*SB+o] = old_img[o];
    end
  endtask

  task automatic build_new(input int off, input logic [7:0] d);
    for (int o = 0; o < SB; o++) new_img[o] = merged(old_img[o], o, off, d);
  endtask

  task automatic clear_log();
    cmd_cnt = 0; prog_cnt = 0; t_fp = -1; t_ld = -1; t_de = -1; fp_wd = -1;
  endtask

  task automatic send_req(input int s, input int o, input logic [7:0] d);
    @(negedge clk);
    req_sector = SW'(s); req_offset = OW'(o); req_data = d; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done(output int seen);
    seen = 0;
    for (int i = 0; i < 8000; i++) begin
      @(negedge clk);
      if (upd_done) begin
        seen++;
        chk(req_ready, "R8 ready with done", int'(req_ready), 1);
        break;
      end
    end
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 8000; i++) begin
      @(negedge clk);
      if (req_ready) break;
    end
  endtask

  task automatic power_cut();
    @(negedge clk);
    cut = 1'b1; rst_n = 1'b0;
    @(negedge clk);
    cut = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R10 actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int seen;
    int s, o;
    logic [7:0] d;
    void'($urandom(32'd20240611));
    for (int i = 0; i < NS*SB; i++) mem[i] = 8'hFF;

    // Reset state and the recovery pass on a clean journal
    repeat (3) @(negedge clk);
    chk(!req_ready, "R2 ready in reset", int'(req_ready), 0);
    chk(!upd_done, "R2 done in reset", int'(upd_done), 0);
    chk(!fl_cmd_valid, "R2 cmd in reset", int'(fl_cmd_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!req_ready, "R2 ready during recovery", int'(req_ready), 0);
    wait_ready();
    chk(cmd_cnt == 1, "R3 commands on clean flag", cmd_cnt, 1);
    chk(lg_op[0] == 3 && lg_sect[0] == FLG, "R2 first cmd reads flag", lg_op[0]*16+lg_sect[0], 3*16+FLG);

    // Directed update on an erased sector
    clear_log();
    for (int i = 0; i < SB; i++) old_img[i] = 8'hFF;
    build_new(5, 8'h5A);
    send_req(1, 5, 8'h5A);
    chk(!req_ready, "R5 ready low while busy", int'(req_ready), 0);
    wait_done(seen);
    chk(seen == 1, "R8 done pulse", seen, 1);
    chk(lg_op[0] == 1 && lg_sect[0] == ADR, "R6 erase address sector first", lg_op[0]*16+lg_sect[0], 16+ADR);
    chk(lg_op[1] == 2 && lg_sect[1] == ADR && lg_wd[1] == 1, "R6 program destination index",
        lg_wd[1], 1);
    chk(lg_op[2] == 1 && lg_sect[2] == DAT, "R6 erase data sector", lg_op[2]*16+lg_sect[2], 16+DAT);
    chk(prog_cnt == 4, "R9 erased bytes skipped", prog_cnt, 4);
    chk(fp_wd == 0 && t_fp > t_ld, "R7 commit after staging", t_fp, t_ld + 1);
    chk(t_de > t_fp, "R11 destination erase after commit", t_de, t_fp + 1);
    chk(diff_new(1) == 0, "R8 destination new image", diff_new(1), 0);
    chk(mem[FLG*SB] == 8'hFF, "R8 flag erased", int'(mem[FLG*SB]), 'hFF);

    // Recovery of a preloaded commit
    for (int i = 0; i < SB; i++) begin
      new_img[i] = (i % 4 == 0) ? 8'hFF : 8'(i * 7 + 3);
      mem[DAT*SB+i] = new_img[i];
      mem[2*SB+i] = 8'($urandom);
    end
    mem[FLG*SB] = 8'h00;
    mem[ADR*SB] = 8'h02;
    power_cut();
    @(negedge clk);
    chk(!req_ready, "R2 ready low in recovery", int'(req_ready), 0);
    wait_done(seen);
    chk(seen == 1, "R4 recovery done pulse", seen, 1);
    chk(diff_new(2) == 0, "R4 recovered destination", diff_new(2), 0);
    chk(mem[FLG*SB] == 8'hFF, "R4 flag erased after recovery", int'(mem[FLG*SB]), 'hFF);

    // Request offered during recovery is held off, then taken
    fill_old(3);
    build_new(9, 8'h11);
    power_cut();
    send_req(3, 9, 8'h11);
    wait_done(seen);
    chk(seen == 1 && diff_new(3) == 0, "R5 request held across recovery", diff_new(3), 0);

    // Random updates
    for (int n = 0; n < 6; n++) begin
      s = int'($urandom % 5); o = int'($urandom % SB); d = 8'($urandom);
      fill_old(s);
      build_new(o, d);
      send_req(s, o, d);
      wait_done(seen);
      chk(seen == 1 && diff_new(s) == 0, "R8 random update", diff_new(s), 0);
    end

    // Power cut swept across the update
    for (int k = 0; k < 28; k++) begin
      bit committed;
      bit finished;
      s = int'($urandom % 5); o = int'($urandom % SB); d = 8'($urandom);
      fill_old(s);
      build_new(o, d);
      send_req(s, o, d);
      finished = 1'b0;
      for (int c = 0; c < 2 + k * 73; c++) begin
        @(negedge clk);
        if (upd_done) finished = 1'b1;
      end
      committed = commit_done || finished;
      power_cut();
      wait_ready();
      if (committed)
        chk(diff_new(s) == 0, "R10 committed update survives", diff_new(s), 0);
      else
        chk(diff_new(s) == 0 || diff_old(s) == 0, "R10 old or new image", diff_old(s), 0);
      chk(mem[FLG*SB] == 8'hFF, "R10 flag clean after recovery", int'(mem[FLG*SB]), 'hFF);
    end

    chk(viol == 0, "R1 no command while busy", viol, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule